// File: doc/BRIEF.md
# Edge-Interrupt GPIO Port

This block is an eight-pin general-purpose I/O port controlled through a small byte-wide register bus. Software sets, per pin, whether the pin drives the pad, what value it drives, and whether a peripheral's signal takes over the pin in place of the software value. Pad inputs go through a two-flop synchronizer before software reads them or the edge logic sees them.

Every pin has its own sticky event flag. A per-pin polarity bit picks whether that flag is set by a rising or a falling transition. A flag is set whether or not its interrupt enable is on, so software can poll it. Software clears a flag by writing the flag register back with that bit at zero. One request line is raised while any flag has its enable bit set.

The register map is: 0 pin level (read-only), 1 output value, 2 direction, 3 peripheral select, 4 edge polarity, 5 interrupt enable, 6 event flags. Address 7 is unused.

Top module: `pin_bank_irq`

## Requirements
- R1: After a synchronous reset every register reads 0x00, pad_oe is 0x00 and irq is low.
- R2: Addresses 1 to 5 (output value, direction, peripheral select, edge polarity, interrupt enable) store the byte written and read it back. bus_rdata is registered: it shows the register selected by bus_addr one clock after the address is applied.
- R3: pad_oe follows the direction register, with a 1 meaning the pin is an output. It updates one clock after the write.
- R4: Each bit of pad_out is alt_out when its peripheral-select bit is 1, and the output-value bit when it is 0. The result is registered, one clock late.
- R5: Address 0 returns pad_in after the two-flop synchronizer. Writes to address 0 change nothing.
- R6: When a pin's polarity bit is 0, a low-to-high change on that pin sets its flag. When the bit is 1, a high-to-low change sets it. The flag is set whatever the interrupt-enable bit holds.
- R7: Flags stay set until software writes address 6. That write loads the written byte, so writing a 0 clears a bit.
- R8: If a hardware edge and a software write to address 6 land in the same clock for the same bit, the bit ends up set.
- R9: irq is high one clock after any bit has both its flag and its enable set, and low one clock after no bit does.
- R10: Address 7 reads 0x00, and writes to it have no effect.
- R11: A transition of the opposite polarity to the one selected leaves the flag clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| pad_in | input | 8 | Raw pad levels |
| alt_out | input | 8 | Peripheral function signals |
| pad_out | output | 8 | Pad drive values |
| pad_oe | output | 8 | Pad output enables |
| irq | output | 1 | Combined port interrupt request |

## Verification
The bench raises a pin edge in exactly the clock where software writes zeros to the flag register. A design that gives the write priority loses that event and reads back 0x00 instead of 0x01.

Both polarities are applied to pins whose polarity bits differ. A design with the edge sense inverted, or one that sets flags on any change, shows extra or missing flag bits.

Flags are raised on disabled pins and then on one enabled pin. This exposes a design that gates flag capture with the enable, and one whose irq ignores the enable mask. Writes to the input and unused addresses, and the peripheral-select mux under two patterns, are also checked at the ports.

// File: rtl/pin_bank_pkg.sv
package pin_bank_pkg;
  localparam int REG_ADDR_W = 3;
  typedef enum logic [REG_ADDR_W-1:0] {
    A_PINS = 3'd0,
    A_OUT  = 3'd1,
    A_DIR  = 3'd2,
    A_ALT  = 3'd3,
    A_FALL = 3'd4,
    A_IEN  = 3'd5,
    A_FLAG = 3'd6
  } reg_addr_e;
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < STAGES; k++) st[k] <= '0;
    end else begin
      st[0] <= din;
      for (int k = 1; k < STAGES; k++) st[k] <= st[k-1];
    end
  end

  assign dout = st[STAGES-1];
endmodule

// File: rtl/pin_edge_flags.sv
module pin_edge_flags #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] level,
  input  logic [W-1:0] fall_sel,
  input  logic         sw_wr,
  input  logic [W-1:0] sw_data,
  output logic [W-1:0] flags
);
  logic [W-1:0] prev_q;
  logic [W-1:0] hw_set;
  logic [W-1:0] flags_q;

  for (genvar i = 0; i < W; i++) begin : g_edge
    assign hw_set[i] = fall_sel[i] ? (prev_q[i] & ~level[i])
                                   : (~prev_q[i] & level[i]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q  <= '0;
      flags_q <= '0;
    end else begin
      prev_q  <= level;
      flags_q <= (sw_wr ? sw_data : flags_q) | hw_set;
    end
  end

  assign flags = flags_q;

  // R7: without a software write no flag bit ever drops
  assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    !sw_wr |=> ((flags_q & $past(flags_q)) == $past(flags_q)));

  // R8: a detected edge survives a same-cycle software write
  assert_hw_wins_R8: assert property (@(posedge clk) disable iff (rst)
    (sw_wr && (hw_set != '0)) |=> ((flags_q & $past(hw_set)) == $past(hw_set)));
endmodule

// File: rtl/pin_bank_irq.sv
module pin_bank_irq
  import pin_bank_pkg::*;
#(
  parameter int PINS = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [REG_ADDR_W-1:0] bus_addr,
  input  logic                  bus_wr,
  input  logic [PINS-1:0]       bus_wdata,
  output logic [PINS-1:0]       bus_rdata,
  input  logic [PINS-1:0]       pad_in,
  input  logic [PINS-1:0]       alt_out,
  output logic [PINS-1:0]       pad_out,
  output logic [PINS-1:0]       pad_oe,
  output logic                  irq
);
  localparam int SYNC_STAGES = 2;

  logic [PINS-1:0] out_q, dir_q, alt_q, fall_q, ien_q;
  logic [PINS-1:0] pin_lvl, flags;
  logic [PINS-1:0] rd_mux, drive_mux;
  logic [PINS-1:0] rdata_q, pad_out_q, pad_oe_q;
  logic            irq_q;
  logic            flag_wr;

  pin_sync #(.W(PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(pad_in), .dout(pin_lvl)
  );

  assign flag_wr = bus_wr && (bus_addr == A_FLAG);

  pin_edge_flags #(.W(PINS)) u_flags (
    .clk(clk), .rst(rst), .level(pin_lvl), .fall_sel(fall_q),
    .sw_wr(flag_wr), .sw_data(bus_wdata), .flags(flags)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q  <= '0;
      dir_q  <= '0;
      alt_q  <= '0;
      fall_q <= '0;
      ien_q  <= '0;
    end else if (bus_wr) begin
      case (bus_addr)
        A_OUT:  out_q  <= bus_wdata;
        A_DIR:  dir_q  <= bus_wdata;
        A_ALT:  alt_q  <= bus_wdata;
        A_FALL: fall_q <= bus_wdata;
        A_IEN:  ien_q  <= bus_wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (bus_addr)
      A_PINS:  rd_mux = pin_lvl;
      A_OUT:   rd_mux = out_q;
      A_DIR:   rd_mux = dir_q;
      A_ALT:   rd_mux = alt_q;
      A_FALL:  rd_mux = fall_q;
      A_IEN:   rd_mux = ien_q;
      A_FLAG:  rd_mux = flags;
      default: rd_mux = '0;
    endcase
  end

  for (genvar i = 0; i < PINS; i++) begin : g_drive
    assign drive_mux[i] = alt_q[i] ? alt_out[i] : out_q[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q   <= '0;
      pad_out_q <= '0;
      pad_oe_q  <= '0;
      irq_q     <= 1'b0;
    end else begin
      rdata_q   <= rd_mux;
      pad_out_q <= drive_mux;
      pad_oe_q  <= dir_q;
      irq_q     <= |(flags & ien_q);
    end
  end

  assign bus_rdata = rdata_q;
  assign pad_out   = pad_out_q;
  assign pad_oe    = pad_oe_q;
  assign irq       = irq_q;

  // R9: an enabled pending flag raises the request on the next clock
  assert_irq_rise_R9: assert property (@(posedge clk) disable iff (rst)
    ((flags & ien_q) != '0) |=> irq);

  // R9: with nothing enabled and pending the request drops
  assert_irq_fall_R9: assert property (@(posedge clk) disable iff (rst)
    ((flags & ien_q) == '0) |=> !irq);

  // R3: output enables track the direction register one clock later
  assert_oe_track_R3: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (pad_oe == $past(dir_q)));
endmodule

// File: tb/pin_bank_irq_tb.sv
module pin_bank_irq_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [7:0] pad_in = '0;
  logic [7:0] alt_out = '0;
  logic [7:0] pad_out, pad_oe;
  logic       irq;

  always #10 clk = ~clk;

  pin_bank_irq u_dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .alt_out(alt_out), .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
  );

  typedef struct {
    int         kind;   // 0 rdata, 1 pad_out, 2 pad_oe, 3 irq
    logic [7:0] value;
    string      tag;
  } exp_t;

  exp_t exp_q[$];
  event sample_ev;
  int   n_checks = 0;
  int   n_fails  = 0;
  bit   done     = 1'b0;

  // monitor: pops the expected item and compares against the port
  initial begin
    forever begin
      @(sample_ev);
      while (exp_q.size() > 0) begin
        exp_t e;
        logic [7:0] got;
        e = exp_q.pop_front();
        case (e.kind)
          0: got = bus_rdata;
          1: got = pad_out;
          2: got = pad_oe;
          default: got = {7'd0, irq};
        endcase
        n_checks++;
        if (got !== e.value) begin
          n_fails++;
          $display("FAIL %s kind=%0d actual=%02h expected=%02h", e.tag, e.kind, got, e.value);
        end
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    bus_addr  = a;
    bus_wdata = d;
    bus_wr    = 1'b1;
    @(negedge clk);
    bus_wr    = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [7:0] exp, input string tag);
    bus_addr = a;
    @(negedge clk);
    exp_q.push_back('{0, exp, tag});
    -> sample_ev;
    #1;
  endtask

  task automatic port_chk(input int kind, input logic [7:0] exp, input string tag);
    exp_q.push_back('{kind, exp, tag});
    -> sample_ev;
    #1;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset state
    for (int a = 0; a < 7; a++) rd(3'(a), 8'h00, "R1");
    port_chk(2, 8'h00, "R1");
    port_chk(3, 8'h00, "R1");

    // R2: register write and readback
    wr(3'd1, 8'hA5);
    wr(3'd2, 8'h3C);
    wr(3'd3, 8'h0F);
    wr(3'd4, 8'hF0);
    wr(3'd5, 8'h81);
    rd(3'd1, 8'hA5, "R2");
    rd(3'd2, 8'h3C, "R2");
    rd(3'd3, 8'h0F, "R2");
    rd(3'd4, 8'hF0, "R2");
    rd(3'd5, 8'h81, "R2");

    // R3: output enables follow direction
    port_chk(2, 8'h3C, "R3");

    // R4: peripheral select mux, two patterns
    alt_out = 8'h3A;
    idle(1);
    port_chk(1, 8'hAA, "R4");
    wr(3'd3, 8'hF0);
    idle(1);
    port_chk(1, 8'h35, "R4");

    // R5: synchronized input, write to address 0 ignored
    wr(3'd0, 8'hFF);
    pad_in = 8'h96;
    idle(3);
    rd(3'd0, 8'h96, "R5");

    // R6/R11: rising on low nibble (pol 0) sets bits 1,2; bit7 rise with pol 1 ignored
    rd(3'd6, 8'h06, "R6");
    rd(3'd6, 8'h06, "R11");
    port_chk(3, 8'h00, "R9");   // flags 0x06 not enabled by 0x81

    // R6: falling on bits 7,4 (pol 1) sets them; bits 1,2 falling with pol 0 ignored
    pad_in = 8'h00;
    idle(4);
    rd(3'd6, 8'h96, "R6");
    port_chk(3, 8'h01, "R9");

    // R7: software clear of bit 7 and stickiness of the rest
    wr(3'd6, 8'h16);
    idle(1);
    port_chk(3, 8'h00, "R9");
    idle(5);
    rd(3'd6, 8'h16, "R7");

    // R8: edge on bit 0 in the same clock as a clear-all write
    pad_in = 8'h01;
    @(negedge clk);
    @(negedge clk);
    wr(3'd6, 8'h00);
    rd(3'd6, 8'h01, "R8");

    // R10: unused address reads zero, write to it changes nothing
    wr(3'd7, 8'hFF);
    rd(3'd7, 8'h00, "R10");
    rd(3'd1, 8'hA5, "R10");
    rd(3'd5, 8'h81, "R10");
    rd(3'd0, 8'h01, "R5");

    idle(2);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end
endmodule